// File: doc/BRIEF.md
# Audio Playback Command Port

This block is the host-facing register front-end of an audio playback engine. A host talks to it through five byte-wide I/O locations. These are a reset location, a command location, a data location, a status location and an interrupt-acknowledge location. Command bytes written to the command location pass through a small parser. The parser answers a version query through a read queue, latches output and input sample rates, and starts or halts a 16-bit single-cycle playback block. A reset handshake on the reset location returns the engine to a clean state and leaves a ready byte of 0xAA in the read queue.

The data path is not part of this block. A one-cycle `sample_tick` strobe from the data path reports that one 16-bit sample was consumed. The block counts these strobes against the programmed block length and raises `irq` when the block is finished. The host clears the interrupt by reading the acknowledge location. The mode, sign and stereo flags and both rates are driven out as plain outputs for the data path.

Top module: `audcmd_port`

## Requirements
- R1: After `rst_n` is released, command-location bit 7 (busy) reads 1 until the ready byte 0xAA is in the read queue. The status location bit 7 then reads 1, and the data location returns 0xAA.
- R2: Writing a byte with bit 0 set and then a byte with bit 0 clear to the reset location (address 0) stops playback, clears `irq`, empties the read queue and zeroes both rates. It then reports busy until 0xAA is queued. A bit-0-clear write that does not follow an arming write has no effect.
- R3: Each byte accepted at the command location (address 2) makes bit 7 of that location read 1 for exactly BUSY_CYCLES cycles. A byte written while busy is dropped.
- R4: Status location (address 3) bit 7 is 1 exactly when a byte waits in the read queue. Each read of the data location (address 1) removes one byte, in arrival order. An empty queue reads 0x00.
- R5: Opcode 0xE1 queues two bytes: the major version (VER_MAJOR, at least 4) and then the minor version (VER_MINOR).
- R6: Opcode 0x41 followed by two bytes, high byte first, sets `out_rate`. Opcode 0x42 does the same for `in_rate`.
- R7: Opcode 0xB0 followed by a mode byte, a count low byte and a count high byte raises `play_active`. It sets `play_signed` from mode bit 4 and `play_stereo` from mode bit 5.
- R8: The count is frames minus one. A block ends on sample tick number count+1 in mono and number 2*(count+1) in stereo. On that tick's clock edge `irq` rises and `play_active` falls.
- R9: Sample ticks while `play_active` is low change nothing.
- R10: Opcode 0xD5 drops `play_active` without raising `irq`.
- R11: Reading the acknowledge location (address 4) returns `irq` in bit 7 and clears `irq`. Reading the status location leaves `irq` set.
- R12: While a multi-byte command still waits for arguments, incoming bytes are taken as its arguments and never decoded as opcodes. Unknown opcodes queue nothing and change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 3 | I/O location select (0 reset, 1 data, 2 command, 3 status, 4 acknowledge) |
| bus_wr | input | 1 | Write strobe, taken at the rising clock edge |
| bus_rd | input | 1 | Read strobe; read side effects happen at the rising clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected location, combinational |
| sample_tick | input | 1 | One 16-bit sample consumed by the data path |
| irq | output | 1 | Block-complete interrupt |
| play_active | output | 1 | Playback block in progress |
| play_signed | output | 1 | Samples are signed |
| play_stereo | output | 1 | Frames hold two samples |
| out_rate | output | 16 | Output sample rate |
| in_rate | output | 16 | Input sample rate |

## Verification
The assertions check several rules on every cycle. An accepted command byte always makes the port busy on the next cycle. An acknowledge read always leaves the interrupt low. The interrupt rises only on a sample tick during playback, and playback starts only after a bus write. A halt opcode taken at an opcode boundary always stops playback. The ready byte is queued on the same edge that ends a reset, and the output rate does not move without a bus write. Some properties need whole command sequences and long counts, so only the bench scenarios can show them. These are the exact block length in mono and stereo frames, the order of the version bytes, the collection of opcode-valued bytes as arguments, the arming rule of the reset handshake, and the exact busy window.

// File: rtl/audcmd_pkg.sv
package audcmd_pkg;
  // I/O location map
  localparam logic [2:0] LOC_RESET = 3'd0;
  localparam logic [2:0] LOC_DATA  = 3'd1;
  localparam logic [2:0] LOC_CMD   = 3'd2;
  localparam logic [2:0] LOC_STAT  = 3'd3;
  localparam logic [2:0] LOC_ACK   = 3'd4;

  // Command opcodes
  localparam logic [7:0] OPC_VERSION  = 8'hE1;
  localparam logic [7:0] OPC_RATE_OUT = 8'h41;
  localparam logic [7:0] OPC_RATE_IN  = 8'h42;
  localparam logic [7:0] OPC_PLAY16   = 8'hB0;
  localparam logic [7:0] OPC_HALT16   = 8'hD5;

  localparam logic [7:0] READY_BYTE   = 8'hAA;

  // Mode byte fields
  localparam int MODE_SIGNED_BIT = 4;
  localparam int MODE_STEREO_BIT = 5;

  typedef enum logic {
    CS_OPCODE,
    CS_ARGS
  } cmd_state_e;
endpackage

// File: rtl/audcmd_rxq.sv
module audcmd_rxq #(
  parameter int DEPTH = 4,
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic             not_empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic             do_push, do_pop;

  assign not_empty = (cnt_q != '0);
  assign dout      = mem[rp_q];
  assign do_push   = push && (cnt_q != FULL);
  assign do_pop    = pop && not_empty;

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (flush) begin
      wp_d  = '0;
      rp_d  = '0;
      cnt_d = '0;
    end else begin
      if (do_push) wp_d = (wp_q == LAST) ? '0 : wp_q + 1'b1;
      if (do_pop)  rp_d = (rp_q == LAST) ? '0 : rp_q + 1'b1;
      if (do_push && !do_pop)      cnt_d = cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  // Storage carries no reset; only the pointers qualify it.
  always_ff @(posedge clk) begin
    if (do_push && !flush) mem[wp_q] <= din;
  end
endmodule

// File: rtl/audcmd_ctrl.sv
module audcmd_ctrl
  import audcmd_pkg::*;
#(
  parameter int BUSY_CYCLES = 4,
  parameter int RST_CYCLES  = 8,
  parameter int VER_MAJOR   = 4,
  parameter int VER_MINOR   = 13
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rst_wr,
  input  logic        rst_bit,
  input  logic        cmd_wr,
  input  logic [7:0]  cmd_byte,
  output logic        busy,
  output logic        resetting,
  output logic        flush,
  output logic        push,
  output logic [7:0]  push_byte,
  output logic        play_start,
  output logic [7:0]  play_mode,
  output logic [15:0] play_count,
  output logic        play_halt,
  output logic [15:0] rate_out,
  output logic [15:0] rate_in,
  output logic        parser_idle
);
  localparam int BW = $clog2(BUSY_CYCLES + 1);
  localparam int RW = $clog2(RST_CYCLES + 1);
  localparam logic [BW-1:0] BUSY_LOAD = BW'(BUSY_CYCLES);
  localparam logic [RW-1:0] RST_LOAD  = RW'(RST_CYCLES);
  localparam logic [7:0]    MAJOR_B   = 8'(VER_MAJOR);
  localparam logic [7:0]    MINOR_B   = 8'(VER_MINOR);

  logic              armed_q, armed_d;
  logic              rsting_q, rsting_d;
  logic [RW-1:0]     rcnt_q, rcnt_d;
  logic [BW-1:0]     bcnt_q, bcnt_d;
  cmd_state_e        cst_q, cst_d;
  logic [7:0]        op_q, op_d;
  logic [1:0]        argi_q, argi_d;
  logic [7:0]        a0_q, a0_d, a1_q, a1_d;
  logic              minor_q, minor_d;
  logic [15:0]       rout_q, rout_d, rin_q, rin_d;
  logic              fire, accept;

  assign busy        = rsting_q || (bcnt_q != '0);
  assign resetting   = rsting_q;
  assign fire        = rst_wr && !rst_bit && armed_q;
  assign flush       = fire;
  assign accept      = cmd_wr && !busy;
  assign play_mode   = a0_q;
  assign play_count  = {cmd_byte, a1_q};
  assign rate_out    = rout_q;
  assign rate_in     = rin_q;
  assign parser_idle = (cst_q == CS_OPCODE);

  always_comb begin
    armed_d    = armed_q;
    rsting_d   = rsting_q;
    rcnt_d     = rcnt_q;
    bcnt_d     = bcnt_q;
    cst_d      = cst_q;
    op_d       = op_q;
    argi_d     = argi_q;
    a0_d       = a0_q;
    a1_d       = a1_q;
    minor_d    = minor_q;
    rout_d     = rout_q;
    rin_d      = rin_q;
    push       = 1'b0;
    push_byte  = 8'h00;
    play_start = 1'b0;
    play_halt  = 1'b0;
    if (fire) begin
      armed_d  = 1'b0;
      rsting_d = 1'b1;
      rcnt_d   = RST_LOAD;
      bcnt_d   = '0;
      cst_d    = CS_OPCODE;
      argi_d   = '0;
      minor_d  = 1'b0;
      rout_d   = '0;
      rin_d    = '0;
    end else begin
      if (rst_wr) armed_d = rst_bit;
      if (rsting_q) begin
        if (rcnt_q == '0) begin
          rsting_d  = 1'b0;
          push      = 1'b1;
          push_byte = READY_BYTE;
        end else begin
          rcnt_d = rcnt_q - 1'b1;
        end
      end
      if (bcnt_q != '0) bcnt_d = bcnt_q - 1'b1;
      if (minor_q) begin
        push      = 1'b1;
        push_byte = MINOR_B;
        minor_d   = 1'b0;
      end
      if (accept) begin
        bcnt_d = BUSY_LOAD;
        if (cst_q == CS_OPCODE) begin
          case (cmd_byte)
            OPC_VERSION: begin
              push      = 1'b1;
              push_byte = MAJOR_B;
              minor_d   = 1'b1;
            end
            OPC_RATE_OUT, OPC_RATE_IN, OPC_PLAY16: begin
              op_d   = cmd_byte;
              argi_d = '0;
              cst_d  = CS_ARGS;
            end
            OPC_HALT16: play_halt = 1'b1;
            default: ;
          endcase
        end else begin
          argi_d = argi_q + 1'b1;
          if (op_q == OPC_PLAY16) begin
            case (argi_q)
              2'd0:    a0_d = cmd_byte;
              2'd1:    a1_d = cmd_byte;
              default: begin
                play_start = 1'b1;
                cst_d      = CS_OPCODE;
              end
            endcase
          end else begin
            if (argi_q == 2'd0) begin
              a0_d = cmd_byte;
            end else begin
              if (op_q == OPC_RATE_OUT) rout_d = {a0_q, cmd_byte};
              else                      rin_d  = {a0_q, cmd_byte};
              cst_d = CS_OPCODE;
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q  <= 1'b0;
      rsting_q <= 1'b1;
      rcnt_q   <= RST_LOAD;
      bcnt_q   <= '0;
      cst_q    <= CS_OPCODE;
      op_q     <= '0;
      argi_q   <= '0;
      a0_q     <= '0;
      a1_q     <= '0;
      minor_q  <= 1'b0;
      rout_q   <= '0;
      rin_q    <= '0;
    end else begin
      armed_q  <= armed_d;
      rsting_q <= rsting_d;
      rcnt_q   <= rcnt_d;
      bcnt_q   <= bcnt_d;
      cst_q    <= cst_d;
      op_q     <= op_d;
      argi_q   <= argi_d;
      a0_q     <= a0_d;
      a1_q     <= a1_d;
      minor_q  <= minor_d;
      rout_q   <= rout_d;
      rin_q    <= rin_d;
    end
  end
endmodule

// File: rtl/audcmd_player.sv
module audcmd_player
  import audcmd_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             start,
  input  logic [7:0]       mode,
  input  logic [CNT_W-1:0] count,
  input  logic             halt,
  input  logic             tick,
  input  logic             ack_clr,
  output logic             active,
  output logic             irq,
  output logic             is_signed,
  output logic             stereo
);
  logic             act_q, act_d;
  logic             irq_q, irq_d;
  logic             sgn_q, sgn_d;
  logic             st_q, st_d;
  logic             half_q, half_d;
  logic [CNT_W-1:0] rem_q, rem_d;
  logic             done;

  assign active    = act_q;
  assign irq       = irq_q;
  assign is_signed = sgn_q;
  assign stereo    = st_q;

  always_comb begin
    act_d  = act_q;
    sgn_d  = sgn_q;
    st_d   = st_q;
    half_d = half_q;
    rem_d  = rem_q;
    done   = 1'b0;
    if (flush) begin
      act_d  = 1'b0;
      sgn_d  = 1'b0;
      st_d   = 1'b0;
      half_d = 1'b0;
      rem_d  = '0;
    end else if (start) begin
      act_d  = 1'b1;
      sgn_d  = mode[MODE_SIGNED_BIT];
      st_d   = mode[MODE_STEREO_BIT];
      half_d = 1'b0;
      rem_d  = count;
    end else if (halt) begin
      act_d = 1'b0;
    end else if (tick && act_q) begin
      if (st_q && !half_q) begin
        half_d = 1'b1;
      end else begin
        half_d = 1'b0;
        if (rem_q == '0) begin
          act_d = 1'b0;
          done  = 1'b1;
        end else begin
          rem_d = rem_q - 1'b1;
        end
      end
    end
    if (flush)        irq_d = 1'b0;
    else if (done)    irq_d = 1'b1;
    else if (ack_clr) irq_d = 1'b0;
    else              irq_d = irq_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      irq_q  <= 1'b0;
      sgn_q  <= 1'b0;
      st_q   <= 1'b0;
      half_q <= 1'b0;
      rem_q  <= '0;
    end else begin
      act_q  <= act_d;
      irq_q  <= irq_d;
      sgn_q  <= sgn_d;
      st_q   <= st_d;
      half_q <= half_d;
      rem_q  <= rem_d;
    end
  end
endmodule

// File: rtl/audcmd_port.sv
module audcmd_port
  import audcmd_pkg::*;
#(
  parameter int BUSY_CYCLES = 4,
  parameter int RST_CYCLES  = 8,
  parameter int RXQ_DEPTH   = 4,
  parameter int VER_MAJOR   = 4,
  parameter int VER_MINOR   = 13
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  bus_addr,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [7:0]  bus_wdata,
  output logic [7:0]  bus_rdata,
  input  logic        sample_tick,
  output logic        irq,
  output logic        play_active,
  output logic        play_signed,
  output logic        play_stereo,
  output logic [15:0] out_rate,
  output logic [15:0] in_rate
);
  logic [1:0]  rsync_q;
  logic        rst_sync_n;
  logic        busy, resetting, flush, push, play_start, play_halt, parser_idle;
  logic [7:0]  push_byte, play_mode, rxq_dout;
  logic [15:0] play_count;
  logic        rx_avail, pop, ack_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_sync_n = rsync_q[1];

  assign pop     = bus_rd && (bus_addr == LOC_DATA);
  assign ack_clr = bus_rd && (bus_addr == LOC_ACK);

  audcmd_ctrl #(
    .BUSY_CYCLES (BUSY_CYCLES),
    .RST_CYCLES  (RST_CYCLES),
    .VER_MAJOR   (VER_MAJOR),
    .VER_MINOR   (VER_MINOR)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .rst_wr      (bus_wr && (bus_addr == LOC_RESET)),
    .rst_bit     (bus_wdata[0]),
    .cmd_wr      (bus_wr && (bus_addr == LOC_CMD)),
    .cmd_byte    (bus_wdata),
    .busy        (busy),
    .resetting   (resetting),
    .flush       (flush),
    .push        (push),
    .push_byte   (push_byte),
    .play_start  (play_start),
    .play_mode   (play_mode),
    .play_count  (play_count),
    .play_halt   (play_halt),
    .rate_out    (out_rate),
    .rate_in     (in_rate),
    .parser_idle (parser_idle)
  );

  audcmd_rxq #(
    .DEPTH (RXQ_DEPTH),
    .WIDTH (8)
  ) u_rxq (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .flush     (flush),
    .push      (push),
    .din       (push_byte),
    .pop       (pop),
    .dout      (rxq_dout),
    .not_empty (rx_avail)
  );

  audcmd_player #(
    .CNT_W (16)
  ) u_player (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .flush     (flush),
    .start     (play_start),
    .mode      (play_mode),
    .count     (play_count),
    .halt      (play_halt),
    .tick      (sample_tick),
    .ack_clr   (ack_clr),
    .active    (play_active),
    .irq       (irq),
    .is_signed (play_signed),
    .stereo    (play_stereo)
  );

  always_comb begin
    case (bus_addr)
      LOC_DATA: bus_rdata = rx_avail ? rxq_dout : 8'h00;
      LOC_CMD:  bus_rdata = {busy, 7'b0};
      LOC_STAT: bus_rdata = {rx_avail, 7'b0};
      LOC_ACK:  bus_rdata = {irq, 7'b0};
      default:  bus_rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/audcmd_port_chk.sv
module audcmd_port_chk
  import audcmd_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  bus_addr,
  input logic        bus_wr,
  input logic        bus_rd,
  input logic [7:0]  bus_wdata,
  input logic        sample_tick,
  input logic        irq,
  input logic        play_active,
  input logic [15:0] out_rate,
  input logic        busy,
  input logic        resetting,
  input logic        rx_avail,
  input logic        parser_idle
);
  // R3
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == LOC_CMD && !busy) |=> busy);

  // R11
  ack_clears_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == LOC_ACK && !(sample_tick && play_active)) |=> !irq);

  // R8
  irq_from_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(sample_tick) && $past(play_active)));

  // R10
  halt_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == LOC_CMD && !busy && parser_idle && bus_wdata == OPC_HALT16)
      |=> !play_active);

  // R2
  ready_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(resetting) |-> rx_avail);

  // R6
  rate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> $stable(out_rate));

  // R7
  start_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(play_active) |-> $past(bus_wr));
endmodule

bind audcmd_port audcmd_port_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .bus_addr    (bus_addr),
  .bus_wr      (bus_wr),
  .bus_rd      (bus_rd),
  .bus_wdata   (bus_wdata),
  .sample_tick (sample_tick),
  .irq         (irq),
  .play_active (play_active),
  .out_rate    (out_rate),
  .busy        (busy),
  .resetting   (resetting),
  .rx_avail    (rx_avail),
  .parser_idle (parser_idle)
);

// File: tb/test_audcmd_port.sv
`timescale 1ns/1ps
module test_audcmd_port;
  localparam int BUSY_N = 4;
  localparam int RST_N  = 8;
  localparam int MAJ    = 4;
  localparam int MIN    = 13;
  localparam logic [2:0] L_RST = 3'd0, L_DAT = 3'd1, L_CMD = 3'd2, L_STA = 3'd3, L_ACK = 3'd4;

  // playback vectors: mode[47:40], count[39:24], sample ticks to finish[23:0]
  localparam logic [47:0] PLAY_TAB [5] = '{
    {8'h00, 16'd0, 24'd1},
    {8'h10, 16'd3, 24'd4},
    {8'h20, 16'd0, 24'd2},
    {8'h30, 16'd2, 24'd6},
    {8'h10, 16'd9, 24'd10}
  };

  logic        clk, rst_n, bus_wr, bus_rd, sample_tick;
  logic [2:0]  bus_addr;
  logic [7:0]  bus_wdata, bus_rdata;
  logic        irq, play_active, play_signed, play_stereo;
  logic [15:0] out_rate, in_rate;
  int n_chk = 0, n_bad = 0, cyc = 0;
  logic [7:0] v;

  audcmd_port #(.BUSY_CYCLES(BUSY_N), .RST_CYCLES(RST_N), .RXQ_DEPTH(4),
                .VER_MAJOR(MAJ), .VER_MINOR(MIN)) i_audcmd_port (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sample_tick(sample_tick), .irq(irq),
    .play_active(play_active), .play_signed(play_signed), .play_stereo(play_stereo),
    .out_rate(out_rate), .in_rate(in_rate));

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: act=%0d exp<=100000 cycles", cyc);
      summary();
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0; #1;
  endtask

  task automatic peek(logic [2:0] a, output logic [7:0] d);
    bus_addr = a; #1 d = bus_rdata;
  endtask

  task automatic wait_ready();
    logic [7:0] s;
    for (int g = 0; g < 2000; g++) begin
      @(negedge clk); peek(L_CMD, s);
      if (!s[7]) break;
    end
  endtask

  task automatic send(logic [7:0] b);
    wait_ready(); wr(L_CMD, b);
  endtask

  task automatic tick();
    @(negedge clk); sample_tick = 1'b1;
    @(negedge clk); sample_tick = 1'b0; #1;
  endtask

  initial begin
    rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; sample_tick = 1'b0;
    bus_addr = L_STA; bus_wdata = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    peek(L_CMD, v); check("R1 busy after reset", v[7], 1);
    check("R1 no playback after reset", {play_active, irq}, 0);
    wait_ready();
    peek(L_STA, v); check("R1 ready byte waiting", v[7], 1);
    rd(L_DAT, v); check("R1 ready byte value", v, 8'hAA);
    peek(L_STA, v); check("R4 queue empty after pop", v[7], 0);
    rd(L_DAT, v); check("R4 empty queue reads zero", v, 0);

    // R9: ticks while idle
    repeat (3) tick();
    check("R9 idle ticks ignored", {irq, play_active}, 0);

    // R3: exact busy window, unknown opcode (R12)
    wait_ready(); wr(L_CMD, 8'h00);
    begin
      int n = 0;
      for (int k = 0; k < 50; k++) begin
        peek(L_CMD, v);
        if (v[7]) n++; else break;
        @(negedge clk);
      end
      check("R3 busy cycles", n, BUSY_N);
    end
    peek(L_STA, v); check("R12 unknown opcode queues nothing", v[7], 0);
    check("R12 unknown opcode keeps rates", {out_rate, in_rate}, 0);

    // R3: byte during busy dropped
    wait_ready(); wr(L_CMD, 8'h41); wr(L_CMD, 8'h12);
    send(8'h34); send(8'h56);
    check("R3 busy byte dropped", out_rate, 16'h3456);

    // R6 / R12
    send(8'h42); send(8'hAC); send(8'h44);
    check("R6 input rate", in_rate, 16'hAC44);
    send(8'h41); send(8'hD5); send(8'hE1);
    check("R12 opcode bytes as arguments", out_rate, 16'hD5E1);
    wait_ready(); peek(L_STA, v); check("R12 no version reply", v[7], 0);
    check("R12 no halt effect", in_rate, 16'hAC44);

    // R5 version
    send(8'hE1); wait_ready();
    peek(L_STA, v); check("R5 reply waiting", v[7], 1);
    rd(L_DAT, v); check("R5 major first", v, MAJ);
    rd(L_DAT, v); check("R5 minor second", v, MIN);
    peek(L_STA, v); check("R4 empty after two pops", v[7], 0);

    // R7 / R8 / R11 table walk
    for (int i = 0; i < 5; i++) begin
      logic [7:0]  md;
      logic [15:0] ct;
      int          nt;
      md = PLAY_TAB[i][47:40]; ct = PLAY_TAB[i][39:24]; nt = int'(PLAY_TAB[i][23:0]);
      send(8'hB0); send(md); send(ct[7:0]); send(ct[15:8]);
      #1;
      check("R7 active after start", play_active, 1);
      check("R7 signed flag", play_signed, md[4]);
      check("R7 stereo flag", play_stereo, md[5]);
      for (int k = 0; k < nt - 1; k++) tick();
      check("R8 not done before last tick", {irq, play_active}, 2'b01);
      tick();
      check("R8 done on last tick", {irq, play_active}, 2'b10);
      rd(L_STA, v); check("R11 status read keeps irq", irq, 1);
      rd(L_ACK, v); check("R11 ack reads irq", v[7], 1);
      check("R11 ack clears irq", irq, 0);
    end

    // R10 halt, then R9 ticks ignored
    send(8'hB0); send(8'h00); send(8'h0A); send(8'h00);
    repeat (3) tick();
    send(8'hD5); #1;
    check("R10 halt stops", play_active, 0);
    repeat (15) tick();
    check("R10 halt raises no irq", irq, 0);

    // R2 reset handshake
    send(8'hB0); send(8'h00); send(8'h00); send(8'h00);
    tick();
    check("R2 setup irq", irq, 1);
    send(8'hB0); send(8'h00); send(8'hFF); send(8'h00);
    send(8'hE1); wait_ready();
    wr(L_RST, 8'h00); #1;
    peek(L_CMD, v); check("R2 unarmed clear ignored busy", v[7], 0);
    check("R2 unarmed clear keeps play", {play_active, irq}, 2'b11);
    peek(L_STA, v); check("R2 unarmed clear keeps queue", v[7], 1);
    wr(L_RST, 8'h01); wr(L_RST, 8'h00); #1;
    check("R2 reset clears play/irq", {play_active, irq}, 0);
    check("R2 reset clears rates", {out_rate, in_rate}, 0);
    peek(L_CMD, v); check("R2 busy during reset", v[7], 1);
    wait_ready();
    rd(L_DAT, v); check("R2 ready byte after handshake", v, 8'hAA);
    peek(L_STA, v); check("R2 old replies flushed", v[7], 0);

    summary();
  end
endmodule